// File: doc/BRIEF.md
# DMA Global Control and Interrupt Aggregator

This block is the shared register island of a multi-channel DMA engine. It holds the switch that turns the whole controller on, a bit that selects a faster operating mode, and two sticky global error flags. One flag records bad addresses and the other records channel stops. Each channel engine reports its events as single-cycle pulses. A channel can report that a transfer finished, that it saw an address error, or that it halted. The block folds all of these into one pending register with one bit per channel. That register drives a single interrupt line towards the CPU.

Software reaches the block over a simple single-cycle register bus. The interrupt handler reads the pending register to find the channels that need service. It then clears the whole register by writing zero to it, and clears the global error flags by rewriting the control register with those flags at zero. To start a channel, software writes a one into that channel's position in the doorbell register. The channel then sees a one-cycle start pulse and begins fetching its descriptor. A separate mask register, readable and writable, tells each channel whether software may program it directly.

Top module: `gdma_global`

## Requirements
- R1: After reset every register reads zero, the interrupt line is low, and no start pulse or mode output is active.
- R2: A done, address-error or halt pulse on channel i sets bit i of the pending register (offset 0x04) on the next clock edge. The bit then stays set until software clears it.
- R3: A write to offset 0x04 keeps only the pending bits whose written data bit is 1, so writing zero clears every bit.
- R4: An event that arrives in the same cycle as a write to offset 0x04 wins, and its pending bit is set after that edge.
- R5: A write to offset 0x00 loads the enable flag from data bit 0 and the fast-mode flag from data bit 31. Both flags appear on their outputs. All bits of the control register other than 0, 2, 3 and 31 read as zero.
- R6: Control bit 2 becomes set when any channel reports an address error, and bit 3 when any channel reports a halt. Each stays set until a write to 0x00 with that bit at 0. A write with the bit at 1 leaves the flag as it was, and an event in the same cycle as a clearing write leaves the flag set.
- R7: The interrupt line is high exactly when at least one pending bit is set and the enable flag is 1.
- R8: A write to offset 0x0C while the enable flag is 1 raises start pulse i for exactly the next cycle for every data bit i that is 1. A write made while the flag is 0 produces no pulse. Offset 0x0C reads as zero.
- R9: Offset 0x1C is a read/write register whose low channel-count bits drive the per-channel programmable outputs.
- R10: Read data is combinational from the address. Any offset other than 0x00, 0x04, 0x0C and 0x1C reads as zero, and a write to such an offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte offset for reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| ch_done_i | input | N_CH | Per-channel transfer-done pulses |
| ch_aerr_i | input | N_CH | Per-channel address-error pulses |
| ch_halt_i | input | N_CH | Per-channel halt pulses |
| irq_o | output | 1 | Aggregated interrupt |
| fetch_go_o | output | N_CH | One-cycle descriptor-fetch start per channel |
| dma_en_o | output | 1 | Global controller enable |
| perf_mode_o | output | 1 | Fast-mode select |
| ch_prog_o | output | N_CH | Per-channel programmable mask |

## Verification
The assertions assume that reset is applied before any event pulse is taken into account. They also assume that the channel event inputs and the bus write signals are stable across each rising edge. The sticky-flag and pending properties take any pattern of simultaneous events as legal, so the stimulus sets event vectors to arbitrary values on random cycles, including cycles that collide with clearing writes. The bench changes every input only on the falling edge. Its random addresses mostly hit the four mapped offsets and sometimes hit an unmapped one. The enable flag is usually left at 1 so that start pulses occur, and it is sometimes cleared so that the gating is tested.

// File: rtl/gdma_pkg.sv
package gdma_pkg;
   localparam int unsigned DATA_W = 32;

   // Byte offsets decoded by software; fixed by the register map.
   localparam logic [11:0] OFF_CTRL = 12'h000;
   localparam logic [11:0] OFF_PEND = 12'h004;
   localparam logic [11:0] OFF_BELL = 12'h00C;
   localparam logic [11:0] OFF_PROG = 12'h01C;

   // Control register field positions.
   localparam int unsigned CB_EN   = 0;
   localparam int unsigned CB_AERR = 2;
   localparam int unsigned CB_HALT = 3;
   localparam int unsigned CB_PERF = 31;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_PEND,
      SEL_BELL,
      SEL_PROG
   } reg_sel_e;

   function automatic reg_sel_e decode_off(input logic [11:0] off);
      case (off)
         OFF_CTRL: decode_off = SEL_CTRL;
         OFF_PEND: decode_off = SEL_PEND;
         OFF_BELL: decode_off = SEL_BELL;
         OFF_PROG: decode_off = SEL_PROG;
         default:  decode_off = SEL_NONE;
      endcase
   endfunction
endpackage

// File: rtl/gdma_ctrl_reg.sv
module gdma_ctrl_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_i,
   input  logic wen_i,
   input  logic wperf_i,
   input  logic wkeep_aerr_i,
   input  logic wkeep_halt_i,
   input  logic aerr_evt_i,
   input  logic halt_evt_i,
   output logic en_o,
   output logic perf_o,
   output logic aerr_o,
   output logic halt_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o   <= 1'b0;
         perf_o <= 1'b0;
         aerr_o <= 1'b0;
         halt_o <= 1'b0;
      end else begin
         if (wr_i) begin
            en_o   <= wen_i;
            perf_o <= wperf_i;
         end
         // Sticky flags: a write can only clear them, and an event wins.
         aerr_o <= (aerr_o & (~wr_i | wkeep_aerr_i)) | aerr_evt_i;
         halt_o <= (halt_o & (~wr_i | wkeep_halt_i)) | halt_evt_i;
      end
   end

   AST_AERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      aerr_evt_i |=> aerr_o); // R6
   AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_o && !(wr_i && !wkeep_halt_i)) |=> halt_o); // R6
   AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (en_o == $past(wen_i))); // R5
endmodule

// File: rtl/gdma_pend.sv
module gdma_pend #(
   parameter int unsigned N_CH = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_i,
   input  logic [N_CH-1:0] wkeep_i,
   input  logic [N_CH-1:0] evt_i,
   output logic [N_CH-1:0] pend_o
);
   for (genvar i = 0; i < N_CH; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pend_o[i] <= 1'b0;
         else
            pend_o[i] <= (pend_o[i] & (~wr_i | wkeep_i[i])) | evt_i[i];
      end
   end

   AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i != '0) |=> ((pend_o & $past(evt_i)) == $past(evt_i))); // R4
   AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wkeep_i == '0) |=> (pend_o == $past(evt_i))); // R3
   AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> ((pend_o & $past(pend_o)) == $past(pend_o))); // R2
endmodule

// File: rtl/gdma_doorbell.sv
module gdma_doorbell #(
   parameter int unsigned N_CH = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_i,
   input  logic            en_i,
   input  logic [N_CH-1:0] bits_i,
   output logic [N_CH-1:0] go_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         go_o <= '0;
      else if (wr_i && en_i)
         go_o <= bits_i;
      else
         go_o <= '0;
   end

   AST_GO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (go_o != '0) |-> $past(en_i && wr_i)); // R8
   AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((go_o != '0) && !wr_i) |=> (go_o == '0)); // R8
endmodule

// File: rtl/gdma_global.sv
module gdma_global
   import gdma_pkg::*;
#(
   parameter int unsigned N_CH   = 8,
   parameter int unsigned ADDR_W = 12,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [31:0]       reg_wdata_i,
   output logic [31:0]       reg_rdata_o,
   input  logic [N_CH-1:0]   ch_done_i,
   input  logic [N_CH-1:0]   ch_aerr_i,
   input  logic [N_CH-1:0]   ch_halt_i,
   output logic              irq_o,
   output logic [N_CH-1:0]   fetch_go_o,
   output logic              dma_en_o,
   output logic              perf_mode_o,
   output logic [N_CH-1:0]   ch_prog_o
);
   if (N_CH < 1 || N_CH > DATA_W) begin : g_bad_nch
      $error("N_CH must lie in 1..32");
   end
   if (ADDR_W < 5 || ADDR_W > 12) begin : g_bad_aw
      $error("ADDR_W must lie in 5..12");
   end

   localparam int unsigned PAD_W = DATA_W - N_CH;

   reg_sel_e          sel;
   logic              wr_ctrl, wr_pend, wr_bell, wr_prog;
   logic              aerr_flag, halt_flag;
   logic [N_CH-1:0]   pend;
   logic [N_CH-1:0]   evt_any;
   logic [N_CH-1:0]   wbits;
   logic              unused_wdata;

   assign sel     = decode_off(12'(reg_addr_i));
   assign wr_ctrl = reg_wr_i && (sel == SEL_CTRL);
   assign wr_pend = reg_wr_i && (sel == SEL_PEND);
   assign wr_bell = reg_wr_i && (sel == SEL_BELL);
   assign wr_prog = reg_wr_i && (sel == SEL_PROG);
   assign wbits   = reg_wdata_i[N_CH-1:0];
   assign evt_any = ch_done_i | ch_aerr_i | ch_halt_i;
   assign unused_wdata = ^reg_wdata_i;

   gdma_ctrl_reg i_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_i         (wr_ctrl),
      .wen_i        (reg_wdata_i[CB_EN]),
      .wperf_i      (reg_wdata_i[CB_PERF]),
      .wkeep_aerr_i (reg_wdata_i[CB_AERR]),
      .wkeep_halt_i (reg_wdata_i[CB_HALT]),
      .aerr_evt_i   (|ch_aerr_i),
      .halt_evt_i   (|ch_halt_i),
      .en_o         (dma_en_o),
      .perf_o       (perf_mode_o),
      .aerr_o       (aerr_flag),
      .halt_o       (halt_flag)
   );

   gdma_pend #(.N_CH(N_CH)) i_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_pend),
      .wkeep_i (wbits),
      .evt_i   (evt_any),
      .pend_o  (pend)
   );

   gdma_doorbell #(.N_CH(N_CH)) i_bell (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (wr_bell),
      .en_i   (dma_en_o),
      .bits_i (wbits),
      .go_o   (fetch_go_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ch_prog_o <= '0;
      else if (wr_prog)
         ch_prog_o <= wbits;
   end

   if (IRQ_REG) begin : g_irq_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= dma_en_o && (pend != '0);
      end
   end else begin : g_irq_comb
      assign irq_o = dma_en_o && (pend != '0);
      AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o |-> (dma_en_o && $countones(pend) > 0)); // R7
   end

   always_comb begin
      reg_rdata_o = '0;
      unique case (sel)
         SEL_CTRL: begin
            reg_rdata_o[CB_EN]   = dma_en_o;
            reg_rdata_o[CB_AERR] = aerr_flag;
            reg_rdata_o[CB_HALT] = halt_flag;
            reg_rdata_o[CB_PERF] = perf_mode_o;
         end
         SEL_PEND: reg_rdata_o = {{PAD_W{1'b0}}, pend};
         SEL_PROG: reg_rdata_o = {{PAD_W{1'b0}}, ch_prog_o};
         SEL_BELL: reg_rdata_o = '0;
         SEL_NONE: reg_rdata_o = '0;
         default:  reg_rdata_o = '0;
      endcase
   end

   AST_NO_GO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_go_o != '0) |-> $past(dma_en_o)); // R8
endmodule

// File: tb/test_gdma_global.sv
`timescale 1ns/1ps
module test_gdma_global;
   localparam int N = 8;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [N-1:0]  dn = '0, ae = '0, ht = '0;
   logic          irq, en, perf;
   logic [N-1:0]  go, prog;

   int checks = 0;
   int errors = 0;

   // model state
   logic          m_en = 0, m_perf = 0, m_aerr = 0, m_halt = 0;
   logic [N-1:0]  m_pend = '0, m_prog = '0, m_go = '0;

   always #2 clk = ~clk;

   gdma_global #(.N_CH(N), .ADDR_W(AW)) i_gdma_global (
      .clk(clk), .rst_n(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ch_done_i(dn),
      .ch_aerr_i(ae), .ch_halt_i(ht), .irq_o(irq), .fetch_go_o(go),
      .dma_en_o(en), .perf_mode_o(perf), .ch_prog_o(prog)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
      case (a)
         12'h000: exp_read = {m_perf, 27'b0, m_halt, m_aerr, 1'b0, m_en};
         12'h004: exp_read = 32'(m_pend);
         12'h01C: exp_read = 32'(m_prog);
         default: exp_read = 32'h0;
      endcase
   endfunction

   function automatic string tag_of(input logic [AW-1:0] a);
      case (a)
         12'h000: tag_of = "R5/R6 ctrl read";
         12'h004: tag_of = "R2/R3/R4 pend read";
         12'h00C: tag_of = "R8 bell read";
         12'h01C: tag_of = "R9 prog read";
         default: tag_of = "R10 unmapped read";
      endcase
   endfunction

   task automatic model_edge();
      logic [N-1:0] ev;
      ev = dn | ae | ht;
      m_go = (wr && addr == 12'h00C && m_en) ? wdata[N-1:0] : '0;
      if (wr && addr == 12'h004) m_pend = (m_pend & wdata[N-1:0]) | ev;
      else                       m_pend = m_pend | ev;
      if (wr && addr == 12'h000) begin
         m_aerr = (m_aerr & wdata[2]) | (|ae);
         m_halt = (m_halt & wdata[3]) | (|ht);
         m_en   = wdata[0];
         m_perf = wdata[31];
      end else begin
         m_aerr = m_aerr | (|ae);
         m_halt = m_halt | (|ht);
      end
      if (wr && addr == 12'h01C) m_prog = wdata[N-1:0];
   endtask

   task automatic step(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                       input logic [N-1:0] vd, input logic [N-1:0] va, input logic [N-1:0] vh);
      @(negedge clk);
      wr = w; addr = a; wdata = d; dn = vd; ae = va; ht = vh;
      #1;
      chk(rdata, exp_read(a), tag_of(a));
      @(posedge clk);
      model_edge();
      #1;
      chk(32'(irq), 32'(m_en && (m_pend != '0)), "R7 irq");
      chk(32'(go), 32'(m_go), "R8 fetch pulse");
      chk({30'b0, perf, en}, {30'b0, m_perf, m_en}, "R5 ctrl outputs");
      chk(32'(prog), 32'(m_prog), "R9 prog output");
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [AW-1:0] ra;
      logic [31:0]   rd;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      foreach (ra[i]) ra[i] = 1'b0;
      for (int k = 0; k < 5; k++) begin
         addr = (k == 0) ? 12'h000 : (k == 1) ? 12'h004 : (k == 2) ? 12'h00C :
                (k == 3) ? 12'h01C : 12'h010;
         #1;
         chk(rdata, 32'h0, "R1 reset read");
         @(negedge clk);
      end
      chk({irq, go, en, perf, prog}, '0, "R1 reset outputs");
      rst_n = 1'b1;

      // directed: events while disabled, then enable
      step(1'b0, 12'h004, 0, 8'h05, 8'h00, 8'h00);
      chk(32'(irq), 32'h0, "R7 irq gated by enable");
      step(1'b1, 12'h00C, 32'hFF, 0, 0, 0);           // R8 bell while disabled
      chk(32'(go), 32'h0, "R8 no pulse while disabled");
      step(1'b1, 12'h000, 32'h8000_0001, 0, 0, 0);
      step(1'b0, 12'h000, 0, 0, 8'h02, 8'h40);        // R6 set flags
      step(1'b1, 12'h000, 32'h0000_000D, 0, 0, 0);    // R6 keep with bits at 1
      step(1'b1, 12'h000, 32'h0000_0001, 0, 0, 8'h01);// R6 halt event wins over clear
      step(1'b1, 12'h004, 32'h0, 8'h80, 0, 0);        // R4 event wins over clear
      chk(32'(m_pend), 32'h80, "R4 model sanity");
      step(1'b1, 12'h004, 32'h0, 0, 0, 0);            // R3 zero clears
      step(1'b1, 12'h00C, 32'hA5, 0, 0, 0);           // R8 pulse
      step(1'b0, 12'h00C, 0, 0, 0, 0);                // R8 pulse ends
      step(1'b1, 12'h010, 32'hFFFF_FFFF, 0, 0, 0);    // R10 unmapped write ignored
      step(1'b0, 12'h01C, 0, 0, 0, 0);

      // random phase
      for (int n = 0; n < 4000; n++) begin
         int pick;
         pick = $urandom % 10;
         ra = (pick < 3) ? 12'h004 : (pick < 5) ? 12'h000 : (pick < 7) ? 12'h00C :
              (pick < 9) ? 12'h01C : 12'($urandom % 64);
         rd = $urandom;
         if (ra == 12'h000 && ($urandom % 5) != 0) rd[0] = 1'b1;
         if (ra == 12'h004 && ($urandom % 2) == 0) rd = 32'h0;
         step(($urandom % 3) == 0, ra, rd,
              (($urandom % 4) == 0) ? N'($urandom) : '0,
              (($urandom % 12) == 0) ? N'($urandom) : '0,
              (($urandom % 12) == 0) ? N'($urandom) : '0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule